// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between an internal request port and an external asynchronous static RAM of 128K words by 16 bits. A requester offers one word per request on a valid/ready handshake, either a read or a write. For a write it also gives a two-bit byte mask. The controller then produces active-low chip enable, write enable, output enable and upper/lower byte enables. It also drives a 17-bit address and a 16-bit data path split into output data, a tristate enable and input data. The controller holds every strobe for a whole number of system clock cycles.

All memory timing figures are parameters given in nanoseconds, together with the clock period. The controller turns each figure into a cycle count by rounding up. Writes are ended by the write-enable edge while output enable stays high. The data bus is driven only once the memory's output turn-off time has passed. The data is then held until the cycle after that edge. Read data is sampled once the longest access time has been counted, and it is returned with a one-cycle valid pulse. After every access there is an idle cycle with all strobes high before the next request can be taken.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is asserted and after it is released with no request, all five strobes are high, the data tristate enable is low, the response valid is low and the request port is ready.
- R2: An accepted write pulls chip enable, write enable and the selected byte enables low in the first cycle. Write enable stays low for exactly WR cycles, where WR is the largest of ceil(pulse width), ceil(chip-enable-to-end), ceil(address-to-end), ceil(byte-enable-to-end) and ceil(turn-off)+ceil(data setup). At the defaults this is 7. Output enable stays high for the whole write.
- R3: Write enable is low only while chip enable is low. Chip enable stays low for one further cycle after write enable rises.
- R4: The data tristate enable rises ceil(turn-off) cycles after the write starts (3 at defaults). It stays high through the cycle after write enable rises. The driven data is unchanged for at least the setup time before write enable rises.
- R5: Request byte mask bit 1 selects the upper byte lane and bit 0 the lower lane. A selected lane has its byte enable low during a write, and an unselected lane keeps it high.
- R6: A read holds chip enable, output enable and both byte enables low for exactly ACC cycles. ACC is the largest of the rounded-up address, chip-enable, output-enable and byte-enable access times (7 at defaults). The data present at the edge ending that window is returned on the response data with a valid pulse one cycle wide, in the cycle after the window.
- R7: The interval from the first strobe cycle to the idle gap is at least ceil(write cycle time) for writes and ceil(read cycle time) for reads.
- R8: After each access there is exactly one cycle with all strobes high and ready low, and ready returns the cycle after. A request offered while ready is low has no effect on the memory.
- R9: Every cycle count is the nanosecond figure divided by the clock period and rounded up, so a nonzero figure gives at least one cycle.
- R10: The address output holds the accepted request's address, unchanged, from the first strobe cycle until ready returns.
- R11: Output enable and write enable are never low together, and the data tristate enable is never high while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Write byte mask, bit 1 upper lane, bit 0 lower lane |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | 17 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_dq_o | output | 16 | Data to the memory |
| mem_dq_oe | output | 1 | Tristate enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
The bench's memory model returns valid data only after 55 ns of chip and output enable low, and junk before that, so a read window one cycle short returns the wrong word. Directed writes with each byte mask followed by read-back separate correct lane decoding from swapped or merged lanes. The all-zero and all-ones addresses show address bits are kept. A request raised while the controller is busy, then read back, shows whether busy-time requests are ignored. A seeded random mix of reads and writes over a small address set checks the strobe timing and data path across many back-to-back orderings.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WPULSE = 3'd1,
    ST_WHOLD  = 3'd2,
    ST_WREC   = 3'd3,
    ST_RACC   = 3'd4,
    ST_RREC   = 3'd5,
    ST_GAP    = 3'd6
  } ctl_state_e;

  // nanoseconds to clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int clk_ns);
    return (ns <= 0) ? 0 : (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
`timescale 1ns/1ps
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int WR_CYC = 7,
  parameter int HZ_CYC = 3,
  parameter int WR_REC = 0,
  parameter int RD_ACC = 7,
  parameter int RD_REC = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_be,
  output logic       req_ready,
  output logic       accept,
  output logic       cap,
  output logic       busy,
  output logic       mem_ce_n,
  output logic       mem_we_n,
  output logic       mem_oe_n,
  output logic       mem_ub_n,
  output logic       mem_lb_n,
  output logic       mem_dq_oe
);
  localparam int CNT_MAX = imax(imax(WR_CYC, WR_REC), imax(RD_ACC, RD_REC));
  localparam int CW      = imax(1, $clog2(CNT_MAX + 1));
  localparam logic [CW-1:0] WR_LAST  = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] WREC_LST = CW'(WR_REC - 1);
  localparam logic [CW-1:0] RD_LAST  = CW'(RD_ACC - 1);
  localparam logic [CW-1:0] RREC_LST = CW'(RD_REC - 1);
  localparam logic [CW-1:0] HZ_IDX   = CW'(HZ_CYC);

  ctl_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    be_q, be_d;
  logic          ce_d, we_d, oe_d, ub_d, lb_d, dqoe_d;

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;

  // next-state process
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    be_d  = be_q;
    cap   = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d  = req_write ? ST_WPULSE : ST_RACC;
        cnt_d = '0;
        be_d  = req_write ? req_be : 2'b11;
      end
      ST_WPULSE: begin
        if (cnt_q == WR_LAST) begin
          st_d  = ST_WHOLD;
          cnt_d = '0;
        end else cnt_d = cnt_q + CW'(1);
      end
      ST_WHOLD: begin
        st_d  = (WR_REC > 0) ? ST_WREC : ST_GAP;
        cnt_d = '0;
      end
      ST_WREC: begin
        if (cnt_q == WREC_LST) st_d = ST_GAP;
        else cnt_d = cnt_q + CW'(1);
      end
      ST_RACC: begin
        if (cnt_q == RD_LAST) begin
          cap   = 1'b1;
          st_d  = (RD_REC > 0) ? ST_RREC : ST_GAP;
          cnt_d = '0;
        end else cnt_d = cnt_q + CW'(1);
      end
      ST_RREC: begin
        if (cnt_q == RREC_LST) st_d = ST_GAP;
        else cnt_d = cnt_q + CW'(1);
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // strobe values for the coming cycle, decoded from the next state
  always_comb begin
    ce_d   = !(st_d == ST_WPULSE || st_d == ST_WHOLD || st_d == ST_RACC);
    we_d   = !(st_d == ST_WPULSE);
    oe_d   = !(st_d == ST_RACC);
    ub_d   = !((st_d == ST_WPULSE || st_d == ST_WHOLD || st_d == ST_RACC) && be_d[1]);
    lb_d   = !((st_d == ST_WPULSE || st_d == ST_WHOLD || st_d == ST_RACC) && be_d[0]);
    dqoe_d = (st_d == ST_WHOLD) || (st_d == ST_WPULSE && cnt_d >= HZ_IDX);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      be_q      <= 2'b00;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      be_q      <= be_d;
      mem_ce_n  <= ce_d;
      mem_we_n  <= we_d;
      mem_oe_n  <= oe_d;
      mem_ub_n  <= ub_d;
      mem_lb_n  <= lb_d;
      mem_dq_oe <= dqoe_d;
    end
  end

  assert_we_in_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  assert_ce_after_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);
  assert_hold_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);
  assert_oe_we_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  assert_bus_oe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
module sram_ctl_dpath #(
  parameter int AW = 17,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          cap,
  input  logic          busy,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (load) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      if (cap) rsp_rdata <= mem_dq_i;
      rsp_valid <= cap;
    end
  end

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr));
endmodule

// File: rtl/sram_async_ctl.sv
`timescale 1ns/1ps
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW      = 17,
  parameter int DW      = 16,
  parameter int CLK_NS  = 8,
  parameter int T_RC    = 55,
  parameter int T_AA    = 55,
  parameter int T_ACE   = 55,
  parameter int T_DOE   = 25,
  parameter int T_DBE   = 55,
  parameter int T_WC    = 55,
  parameter int T_SCE   = 45,
  parameter int T_AWE   = 45,
  parameter int T_PWE   = 40,
  parameter int T_SD    = 25,
  parameter int T_BW    = 50,
  parameter int T_HZ    = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int C_HZ   = ns2cyc(T_HZ, CLK_NS);
  localparam int C_SD   = imax(1, ns2cyc(T_SD, CLK_NS));
  localparam int WR_CYC = imax(imax(ns2cyc(T_PWE, CLK_NS), ns2cyc(T_SCE, CLK_NS)),
                               imax(imax(ns2cyc(T_AWE, CLK_NS), ns2cyc(T_BW, CLK_NS)),
                                    C_HZ + C_SD));
  localparam int WR_TOT = imax(ns2cyc(T_WC, CLK_NS), WR_CYC + 1);
  localparam int WR_REC = WR_TOT - WR_CYC - 1;
  localparam int RD_ACC = imax(1, imax(imax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_ACE, CLK_NS)),
                                       imax(ns2cyc(T_DOE, CLK_NS), ns2cyc(T_DBE, CLK_NS))));
  localparam int RD_TOT = imax(ns2cyc(T_RC, CLK_NS), RD_ACC);
  localparam int RD_REC = RD_TOT - RD_ACC;

  logic rst_s_n, accept, cap, busy;

  sram_rst_sync i_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_s_n)
  );

  sram_ctl_seq #(
    .WR_CYC(WR_CYC), .HZ_CYC(C_HZ), .WR_REC(WR_REC),
    .RD_ACC(RD_ACC), .RD_REC(RD_REC)
  ) i_seq (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_be   (req_be),
    .req_ready(req_ready),
    .accept   (accept),
    .cap      (cap),
    .busy     (busy),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_ub_n (mem_ub_n),
    .mem_lb_n (mem_lb_n),
    .mem_dq_oe(mem_dq_oe)
  );

  sram_ctl_dpath #(.AW(AW), .DW(DW)) i_dpath (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (accept),
    .cap      (cap),
    .busy     (busy),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .mem_dq_i (mem_dq_i),
    .mem_addr (mem_addr),
    .mem_dq_o (mem_dq_o),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );
endmodule

// File: tb/test_sram_async_ctl.sv
`timescale 1ns/1ps
module test_sram_async_ctl;
  localparam int TCK = 8;
  function automatic int cdiv(input int ns);
    return (ns + TCK - 1) / TCK;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  // expected counts from the nanosecond figures (R9)
  localparam int E_HZ   = cdiv(20);
  localparam int E_WR   = mx(mx(cdiv(40), cdiv(45)), mx(cdiv(50), cdiv(20) + cdiv(25)));
  localparam int E_WTOT = mx(cdiv(55), E_WR + 1);
  localparam int E_ACC  = mx(mx(cdiv(55), cdiv(25)), cdiv(55));
  localparam int E_RTOT = mx(cdiv(55), E_ACC);

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;

  sram_async_ctl i_sram_async_ctl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0, armed = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin clk = 0; forever #4 clk = ~clk; end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // ---------------- memory model and shadow ----------------
  logic [15:0] mdl [int];
  logic [15:0] shd [int];
  real t_rd, t_dchg;
  bit  rd_on_prev = 0;

  function automatic logic [15:0] mrd(input int a);
    return mdl.exists(a) ? mdl[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] srd(input int a);
    return shd.exists(a) ? shd[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n,
                                        input logic [1:0] be);
    return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
  endfunction

  // data valid only 55 ns after chip and output enable are both low
  initial begin
    mem_dq_i = 16'hBAD0;
    #0.5;
    forever begin
      if (!mem_ce_n && !mem_oe_n) begin
        if (!rd_on_prev) t_rd = $realtime;
        rd_on_prev = 1;
        mem_dq_i = ($realtime - t_rd >= 55.0) ? mrd(int'(mem_addr)) : 16'hBAD0;
      end else begin
        rd_on_prev = 0;
        mem_dq_i = 16'hBAD0;
      end
      #1;
    end
  end

  always @(mem_dq_o or mem_dq_oe) t_dchg = $realtime;

  always @(posedge mem_we_n) if (armed) begin
    chk(!mem_ce_n, "R3 ce low at write end", mem_ce_n, 0);
    chk(mem_dq_oe, "R4 bus driven at write end", mem_dq_oe, 1);
    chk($realtime - t_dchg >= 25.0, "R4 data setup ns", int'($realtime - t_dchg), 25);
    mdl[int'(mem_addr)] = merge(mrd(int'(mem_addr)), mem_dq_o, {!mem_ub_n, !mem_lb_n});
  end

  // ---------------- transaction tasks ----------------
  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be,
                          input bit poke, input logic [16:0] pa);
    int we_lo = 0, ce_lo = 0, first = -1, last = -1, rdy = -1;
    bit bad_ce = 0, bad_oe = 0, bad_addr = 0, gap_ok = 0;
    logic [1:0] lanes = 2'b00;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 0;
    shd[int'(a)] = merge(srd(int'(a)), d, be);
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk);
      if (req_ready) begin rdy = k; break; end
      if (poke && k == 1) begin
        req_valid = 1; req_write = 1; req_addr = pa; req_wdata = ~d; req_be = 2'b11;
      end
      if (poke && k == 4) req_valid = 0;
      if (!mem_we_n) we_lo++;
      if (!mem_ce_n) ce_lo++;
      if (!mem_we_n && mem_ce_n) bad_ce = 1;
      if (!mem_oe_n) bad_oe = 1;
      if (mem_dq_oe) begin if (first < 0) first = k; last = k; end
      if (k == 0) lanes = {!mem_ub_n, !mem_lb_n};
      if (mem_addr !== a) bad_addr = 1;
      if (k == E_WTOT) gap_ok = mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n;
    end
    chk(we_lo == E_WR, "R2 R9 write pulse cycles", we_lo, E_WR);
    chk(!bad_oe, "R2 R11 oe high in write", bad_oe, 0);
    chk(!bad_ce && ce_lo == E_WR + 1, "R3 ce low cycles", ce_lo, E_WR + 1);
    chk(first == E_HZ, "R4 bus drive start", first, E_HZ);
    chk(last == E_WR, "R4 bus drive end", last, E_WR);
    chk(lanes == be, "R5 byte lanes", lanes, be);
    chk(!bad_addr, "R10 address stable", bad_addr, 0);
    chk(gap_ok, "R8 idle gap strobes", gap_ok, 1);
    chk(rdy == E_WTOT + 1, "R7 R8 write ready return", rdy, E_WTOT + 1);
  endtask

  task automatic do_read(input logic [16:0] a);
    int acc = 0, vk = -1, vn = 0, rdy = -1;
    bit bad_we = 0, bad_addr = 0;
    logic [15:0] got = '0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = $urandom; req_be = 2'b00;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk);
      if (req_ready) begin rdy = k; break; end
      if (!mem_ce_n && !mem_oe_n && !mem_ub_n && !mem_lb_n) acc++;
      if (!mem_we_n || mem_dq_oe) bad_we = 1;
      if (rsp_valid) begin vn++; vk = k; got = rsp_rdata; end
      if (mem_addr !== a) bad_addr = 1;
    end
    chk(acc == E_ACC, "R6 R9 read window cycles", acc, E_ACC);
    chk(!bad_we, "R11 no write or drive in read", bad_we, 0);
    chk(vn == 1 && vk == E_ACC, "R6 valid pulse position", vk, E_ACC);
    chk(got == srd(int'(a)), "R6 read data", got, srd(int'(a)));
    chk(!bad_addr, "R10 read address stable", bad_addr, 0);
    chk(rdy == E_RTOT + 1, "R7 R8 read ready return", rdy, E_RTOT + 1);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5A17));
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe && !rsp_valid,
        "R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 5'b11100);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rsp_valid,
        "R1 idle after reset", {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
    armed = 1;

    // directed: byte lanes and corner addresses
    do_write(17'h00000, 16'h1234, 2'b11, 0, '0);
    do_read (17'h00000);
    do_write(17'h1FFFF, 16'hA5C3, 2'b11, 0, '0);
    do_read (17'h1FFFF);
    do_write(17'h00000, 16'hFF00, 2'b10, 0, '0);   // R5 upper only
    do_read (17'h00000);
    do_write(17'h00000, 16'h00EE, 2'b01, 0, '0);   // R5 lower only
    do_read (17'h00000);
    do_write(17'h00000, 16'h7777, 2'b00, 0, '0);   // R5 no lane
    do_read (17'h00000);
    // R8: request raised while busy must not reach memory
    do_write(17'h00010, 16'h4242, 2'b11, 1, 17'h00020);
    do_read (17'h00020);
    do_read (17'h00010);

    // seeded random mix
    for (int i = 0; i < 60; i++) begin
      logic [16:0] a;
      case ($urandom % 4)
        0: a = 17'h00000;
        1: a = 17'h1FFFF;
        default: a = 17'(($urandom % 6) + 17'h00100);
      endcase
      if ($urandom % 2) do_write(a, 16'($urandom), 2'($urandom), 0, '0);
      else do_read(a);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule